// File: doc/BRIEF.md
# Paged EEPROM Write Engine

This block is the device-side controller of a byte-wide nonvolatile memory that sits behind an SRAM-like parallel bus. The bus has active-low chip enable, output enable and write enable strobes, a 17-bit address and 8-bit data. The host writes a burst of one to 128 bytes that all fall in one page. The block captures each byte's offset and data in a page latch. When the bus has been quiet for a short window, the block commits the gathered bytes to its storage array under an internal timer. The host does not have to keep the address or data bus driven during that time.

Address bits [16:7] pick the page and bits [6:0] pick the byte within it. A separate select input redirects an access to a 128-byte identification area, which is read and written the same way as the main array. While a write is in progress, a read does not return array contents. It returns a polling pattern whose bit 7 is the inverse of bit 7 of the last byte accepted. The host therefore knows the write is finished when bit 7 matches what it wrote.

The millisecond programming time is replaced by a cycle count, `WR_CYC`. Storage is a register array that keeps the low `STORE_W` address bits, so higher pages alias onto it.

Top module: `page_eeprom`

## Requirements
- R1: After reset the output is 8'h00, and every byte of both the main array and the identification area reads 8'hFF.
- R2: A burst of 1 to 128 byte writes to one page stores each byte at the offset given by addr[6:0] of that page. The main array is indexed by addr[STORE_W-1:0], so pages that differ only above bit STORE_W-1 share storage.
- R3: While the page is loading, a write whose page index (addr[16:7] together with id_sel) differs from that of the first byte of the burst is ignored.
- R4: The commit starts LOAD_WIN cycles after the last accepted write strobe, provided no accepted strobe arrives in between.
- R5: The commit lasts WR_CYC cycles. The array is updated when it ends, and the offsets of the page that were not loaded keep their old values.
- R6: From the first accepted strobe until the commit ends, a read returns 8'h80 if bit 7 of the last accepted byte was 0, and 8'h00 if it was 1.
- R7: When no write is in progress, a read returns the stored byte. When no read is selected, the output is 8'h00.
- R8: Write strobes that arrive during the commit are ignored and do not start a new page.
- R9: With id_sel high, an access reaches the 128-byte identification area at offset addr[6:0] and leaves the main array untouched.
- R10: A write strobe is a cycle in which ce_n and we_n are both low after a cycle in which they were not both low. Holding we_n low writes one byte, and we_n low with ce_n high writes nothing. A read is selected when ce_n and oe_n are low and we_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| id_sel | input | 1 | Selects the identification area |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling status |

## Verification
The assertions assume that the bus inputs are synchronous to clk and free of unknown values. They also assume that each write strobe is a real edge, so a byte arrives only after ce_n or we_n has been released for a cycle. The bench meets these conditions by changing every input on the falling clock edge. It separates bytes by an idle cycle, which keeps consecutive strobes well inside the load window. It tests the held-strobe and ce_n-high cases on purpose, against the R10 rule. Every read in the bench is made with we_n high, so reads never produce a strobe.

// File: rtl/page_eeprom.sv
module page_eeprom #(
  parameter int ADDR_W   = 17,
  parameter int PAGE_B   = 7,
  parameter int STORE_W  = 10,
  parameter int LOAD_WIN = 8,
  parameter int WR_CYC   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              id_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout
);
  localparam int PAGE_N  = 1 << PAGE_B;
  localparam int STORE_N = 1 << STORE_W;
  localparam int TAG_W   = ADDR_W - PAGE_B + 1;
  localparam int SLOT_W  = STORE_W - PAGE_B;
  localparam int WIN_W   = $clog2(LOAD_WIN + 1);
  localparam int TMR_W   = $clog2(WR_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_COMMIT} st_t;
  st_t st;

  logic              wr_act, wr_q, wr_stb, rd, tag_hit, accept;
  logic              loading, committing, busy, commit_fire;
  logic [TAG_W-1:0]  tag_in, page_tag;
  logic [PAGE_B-1:0] off;
  logic [WIN_W-1:0]  win;
  logic [TMR_W-1:0]  tmr;
  logic [PAGE_N-1:0] mask;
  logic              last_d7;
  logic [7:0]        lat_d [PAGE_N];
  logic [7:0]        mem   [STORE_N];
  logic [7:0]        idmem [PAGE_N];
  logic [7:0]        rdata;

  assign wr_act      = !ce_n && !we_n;
  assign wr_stb      = wr_act && !wr_q;
  assign rd          = !ce_n && !oe_n && we_n;
  assign tag_in      = {id_sel, addr[ADDR_W-1:PAGE_B]};
  assign off         = addr[PAGE_B-1:0];
  assign tag_hit     = tag_in == page_tag;
  assign loading     = st == S_LOAD;
  assign committing  = st == S_COMMIT;
  assign busy        = loading || committing;
  assign accept      = wr_stb && ((st == S_IDLE) || (loading && tag_hit));
  assign commit_fire = committing && (tmr == TMR_W'(WR_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wr_q     <= 1'b0;
      win      <= '0;
      tmr      <= '0;
      page_tag <= '0;
      mask     <= '0;
      last_d7  <= 1'b0;
    end else begin
      wr_q <= wr_act;
      case (st)
        S_IDLE: begin
          if (wr_stb) begin
            st       <= S_LOAD;
            page_tag <= tag_in;
            mask     <= PAGE_N'(1) << off;
            last_d7  <= din[7];
            win      <= '0;
          end
        end
        S_LOAD: begin
          if (wr_stb && tag_hit) begin
            mask[off] <= 1'b1;
            last_d7   <= din[7];
            win       <= '0;
          end else if (win == WIN_W'(LOAD_WIN - 1)) begin
            st  <= S_COMMIT;
            tmr <= '0;
          end else begin
            win <= win + 1'b1;
          end
        end
        S_COMMIT: begin
          if (commit_fire) st <= S_IDLE;
          else             tmr <= tmr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) lat_d[off] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STORE_N; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_N; i++)  idmem[i] <= 8'hFF;
    end else if (commit_fire) begin
      for (int i = 0; i < PAGE_N; i++) begin
        if (mask[i]) begin
          if (page_tag[TAG_W-1]) idmem[i] <= lat_d[i];
          else mem[{page_tag[SLOT_W-1:0], PAGE_B'(i)}] <= lat_d[i];
        end
      end
    end
  end

  assign rdata = id_sel ? idmem[off] : mem[addr[STORE_W-1:0]];
  assign dout  = !rd  ? 8'h00 :
                 busy ? {~last_d7, 7'b0} : rdata;
endmodule

// File: rtl/page_eeprom_sva.sv
module page_eeprom_sva #(
  parameter int LOAD_WIN = 8,
  parameter int WR_CYC   = 64,
  parameter int WIN_W    = 4,
  parameter int TMR_W    = 7,
  parameter int TAG_W    = 11,
  parameter int PAGE_N   = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic              tag_hit,
  input logic              loading,
  input logic              committing,
  input logic [WIN_W-1:0]  win,
  input logic [TMR_W-1:0]  tmr,
  input logic [PAGE_N-1:0] mask,
  input logic [TAG_W-1:0]  page_tag,
  input logic              last_d7
);
  a_r4_commit_start: assert property (@(posedge clk) disable iff (!rst_n)
    loading && !(wr_stb && tag_hit) && win == WIN_W'(LOAD_WIN - 1) |=> committing);

  a_r5_timer_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(committing) |-> tmr == '0);

  a_r5_commit_end: assert property (@(posedge clk) disable iff (!rst_n)
    committing && tmr == TMR_W'(WR_CYC - 1) |=> !loading && !committing);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    committing |=> $stable(mask) && $stable(page_tag) && $stable(last_d7));

  a_r3_foreign_page: assert property (@(posedge clk) disable iff (!rst_n)
    loading && wr_stb && !tag_hit |=> $stable(mask) && $stable(page_tag));

  a_r2_page_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (loading || committing) |-> mask != '0);
endmodule

bind page_eeprom page_eeprom_sva #(
  .LOAD_WIN(LOAD_WIN), .WR_CYC(WR_CYC), .WIN_W(WIN_W),
  .TMR_W(TMR_W), .TAG_W(TAG_W), .PAGE_N(PAGE_N)
) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .tag_hit(tag_hit),
  .loading(loading), .committing(committing), .win(win), .tmr(tmr),
  .mask(mask), .page_tag(page_tag), .last_d7(last_d7)
);

// File: tb/page_eeprom_bench.sv
module page_eeprom_bench;
  localparam int CLK_P    = 10;
  localparam int LOAD_WIN = 4;
  localparam int WR_CYC   = 24;
  localparam int STORE_W  = 10;
  localparam int STORE_N  = 1 << STORE_W;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, id_sel = 0;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;

  int nchk = 0, nerr = 0;

  page_eeprom #(.STORE_W(STORE_W), .LOAD_WIN(LOAD_WIN), .WR_CYC(WR_CYC)) u_page_eeprom (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .id_sel(id_sel), .addr(addr), .din(din), .dout(dout));

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  bit [7:0] m_mem [int];
  bit [7:0] m_lat [int];
  int m_state = 0, m_win = 0, m_tmr = 0, m_tag = 0;
  bit m_last7 = 0, m_prev = 0;

  function automatic int key(bit id, int a);
    return id ? 32'h100000 + (a & 127) : (a & (STORE_N - 1));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mem.delete(); m_lat.delete();
      m_state = 0; m_win = 0; m_tmr = 0; m_prev = 0;
    end else begin
      bit w, s;
      int t;
      w = !ce_n && !we_n;
      s = w && !m_prev;
      m_prev = w;
      t = (int'(id_sel) << 20) + int'(addr >> 7);
      if (m_state == 0) begin
        if (s) begin
          m_tag = t; m_lat.delete();
          m_lat[key(id_sel, int'(addr))] = din;
          m_last7 = din[7]; m_win = 0; m_state = 1;
        end
      end else if (m_state == 1) begin
        if (s && t == m_tag) begin
          m_lat[key(id_sel, int'(addr))] = din;
          m_last7 = din[7]; m_win = 0;
        end else if (m_win == LOAD_WIN - 1) begin
          m_state = 2; m_tmr = 0;
        end else m_win++;
      end else begin
        if (m_tmr == WR_CYC - 1) begin
          foreach (m_lat[k]) m_mem[k] = m_lat[k];
          m_state = 0;
        end else m_tmr++;
      end
    end
  end

  function automatic logic [7:0] model_dout();
    int k;
    if (!(!ce_n && !oe_n && we_n)) return 8'h00;
    if (m_state != 0) return {~m_last7, 7'b0};
    k = key(id_sel, int'(addr));
    return m_mem.exists(k) ? m_mem[k] : 8'hFF;
  endfunction

  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      logic [7:0] e;
      e = model_dout();
      nchk++;
      if (dout !== e) begin
        nerr++;
        $display("FAIL %s cycle compare: actual %h expected %h",
                 (m_state != 0) ? "R6" : "R7", dout, e);
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(bit id, int a, logic [7:0] d);
    @(negedge clk);
    id_sel = id; addr = 17'(a); din = d; ce_n = 0; we_n = 0;
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic rdb(bit id, int a, output logic [7:0] v);
    @(negedge clk);
    id_sel = id; addr = 17'(a); we_n = 1; ce_n = 0; oe_n = 0;
    #(CLK_P/4);
    v = dout;
    @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  // called at a falling edge; counts busy samples until bit 7 matches
  task automatic poll(bit id, int a, bit e7, output int n);
    id_sel = id; addr = 17'(a); we_n = 1; ce_n = 0; oe_n = 0;
    n = 0;
    #(CLK_P/4);
    while (dout[7] !== e7 && n < 5000) begin
      n++;
      @(negedge clk);
      #(CLK_P/4);
    end
    @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  function automatic int pa(int page, int o);
    return (page << 7) | o;
  endfunction

  function automatic logic [7:0] fdat(int i);
    return 8'(i * 7 + 3);
  endfunction

  initial begin
    #(CLK_P * 150000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #(CLK_P/4);
    chk("R1 idle output", dout, 8'h00);
    rdb(0, 5, v);            chk("R1 erased main", v, 8'hFF);
    rdb(1, 17'h1FF85, v);    chk("R1 erased id", v, 8'hFF);

    // single byte, latency and polling (R4 R5 R6 R7)
    wr(0, pa(3, 10), 8'hA5);
    #(CLK_P/4);
    chk("R6 poll pattern", dout, 8'h00);
    poll(0, pa(3, 10), 1'b1, n);
    nchk++;
    if (n != LOAD_WIN + WR_CYC) begin
      nerr++;
      $display("FAIL R4/R5 busy length: actual %0d expected %0d", n, LOAD_WIN + WR_CYC);
    end
    rdb(0, pa(3, 10), v);    chk("R7 readback", v, 8'hA5);

    // full page (R2)
    for (int i = 0; i < 128; i++) wr(0, pa(5, i), fdat(i));
    poll(0, pa(5, 0), fdat(127)[7], n);
    for (int i = 0; i < 128; i++) begin
      rdb(0, pa(5, i), v);
      chk("R2 full page", v, fdat(i));
    end
    rdb(0, pa(13, 9), v);    chk("R2 alias", v, fdat(9));

    // partial page with a foreign byte (R3 R5)
    for (int i = 10; i < 17; i++) begin
      wr(0, pa(2, i), 8'(8'h40 + i));
      if (i == 12) wr(0, pa(9, 0), 8'hEE);
      if (i == 13) wr(1, pa(2, 20), 8'hDD);
    end
    poll(0, pa(2, 10), 1'b0, n);
    rdb(0, pa(9, 0), v);     chk("R3 foreign page", v, 8'hFF);
    rdb(1, pa(2, 20), v);    chk("R3 foreign area", v, 8'hFF);
    rdb(0, pa(2, 14), v);    chk("R2 partial", v, 8'h4E);
    rdb(0, pa(2, 9), v);     chk("R5 unloaded offset", v, 8'hFF);

    // write during commit (R8)
    wr(0, pa(8, 0), 8'h5A);
    repeat (LOAD_WIN + 2) @(negedge clk);
    wr(0, pa(14, 1), 8'h77);
    poll(0, pa(8, 0), 1'b0, n);
    rdb(0, pa(14, 1), v);    chk("R8 ignored write", v, 8'hFF);
    rdb(0, pa(8, 0), v);     chk("R8 committed byte", v, 8'h5A);

    // identification area (R9)
    wr(1, 17'h1FFFD, 8'h31);
    wr(1, 17'h1FFFE, 8'hC2);
    wr(1, 17'h1FFFF, 8'h13);
    poll(1, 17'h1FFFD, 1'b0, n);
    rdb(1, 17'h1FFFE, v);    chk("R9 id read", v, 8'hC2);
    rdb(1, 17'h1FFFF, v);    chk("R9 id read", v, 8'h13);
    rdb(0, 17'h1FFFD, v);    chk("R9 main untouched", v, 8'hFF);

    // strobe rules (R10)
    @(negedge clk);
    id_sel = 0; addr = 17'(pa(15, 3)); din = 8'h11; ce_n = 0; we_n = 0;
    @(negedge clk); din = 8'h22;
    @(negedge clk); din = 8'h33;
    @(negedge clk); ce_n = 1; we_n = 1;
    poll(0, pa(15, 3), 1'b0, n);
    rdb(0, pa(15, 3), v);    chk("R10 held strobe", v, 8'h11);
    @(negedge clk);
    addr = 17'(pa(17, 4)); din = 8'h99; ce_n = 1; we_n = 0;
    repeat (3) @(negedge clk);
    we_n = 1;
    rdb(0, pa(17, 4), v);    chk("R10 deselected write", v, 8'hFF);

    repeat (4) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule